// File: doc/BRIEF.md
# Dual-Law Serial Clock Divider

This block derives the serial clock of an SPI controller from the system bus clock. A law-select bit chooses between two ways of reading an 8-bit divider value N. The exponential law divides the bus clock by 2^(N+1). The linear law divides it by 2×(N+1). For each half period the block issues a one-cycle enable pulse and toggles a registered serial clock. Alongside the toggle it issues a launch or sample strobe, so that a neighbouring shift engine knows which edge is coming.

The block takes a copy of the law, the divider, the idle polarity and the phase only while the global enable is low. Software sets them with the controller disabled and then enables it again. While a frame is inactive the counter is held at zero and the serial clock rests at the idle polarity. Every frame therefore starts with the same first-edge timing.

Top module: `spi_clkdiv`

## Requirements
- R1: While reset is held, and on the first cycle after it, sclk_o is 0 and tick_o, launch_o and sample_o are 0. The latched configuration resets to exponential law, N=0, polarity 0, phase 0.
- R2: With law_i=0 latched, the half period of sclk_o is 2^N bus cycles for N from 0 to 15. The full serial period is 2^(N+1) cycles.
- R3: With law_i=0 latched and N above 15, N is treated as 15, which gives a half period of 32768 cycles.
- R4: With law_i=1 latched, the half period is N+1 bus cycles for N from 0 to 255. The full serial period is 2×(N+1) cycles.
- R5: With N=0 under either law, sclk_o toggles on every bus cycle. No setting gives a serial clock faster than half the bus clock.
- R6: law_i, div_i, cpol_i and cpha_i are captured only while en_i is 0. Changes while en_i is 1 have no effect until the next disabled cycle.
- R7: Whenever the block is disabled or frame_i is low, sclk_o returns to the latched polarity on the next cycle and stays there.
- R8: The first toggle of a frame is the leading edge. With phase 0, launch_o pulses with each leading-edge tick and sample_o pulses with each trailing-edge tick. With phase 1 the two roles are swapped.
- R9: The divider count restarts at zero at the start of each frame. The first toggle occurs exactly one half period after frame_i rises, whatever partial count a previous frame left behind.
- R10: launch_o and sample_o never pulse together, and each pulses only with tick_o. sclk_o changes on the clock edge that ends a tick_o cycle and holds otherwise while active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| en_i | input | 1 | Global controller enable; low allows configuration capture |
| law_i | input | 1 | Division law: 0 exponential, 1 linear |
| div_i | input | 8 | Divider value N |
| cpol_i | input | 1 | Idle level of the serial clock |
| cpha_i | input | 1 | Phase: swaps the launch and sample edges |
| frame_i | input | 1 | High while a transfer is in progress |
| tick_o | output | 1 | One-cycle pulse ending each serial half period |
| sclk_o | output | 1 | Serial clock |
| launch_o | output | 1 | Tick that precedes a launch edge |
| sample_o | output | 1 | Tick that precedes a sample edge |

## Verification
The bench measures the distance between serial clock toggles under both laws, including N=0, N=255 and an exponential N above 15. A design that mixed up the two laws, or left out the +1 in either law, would show the wrong count there. A design without the clamp would wrap the exponent to a short period. The bench changes the divider and polarity while the block is enabled and checks that nothing moves until a disable. It cuts a frame short and starts a new one, which catches a counter that keeps a stale partial count. It checks that the idle level comes back when a frame is dropped mid-period. In both phase settings it checks which strobe goes with the first edge of a frame, so a swapped or missing phase inversion is reported.

// File: rtl/spi_clkdiv_pkg.sv
package spi_clkdiv_pkg;

    parameter int unsigned SCD_DIV_W   = 8;
    parameter int unsigned SCD_EXP_MAX = 15;
    localparam int unsigned SCD_EXP_W  = $clog2(SCD_EXP_MAX + 1);
    localparam int unsigned SCD_CNT_W  =
        (SCD_EXP_MAX > SCD_DIV_W) ? SCD_EXP_MAX : SCD_DIV_W;

    typedef enum logic {
        LAW_EXP = 1'b0,
        LAW_LIN = 1'b1
    } law_e;

    typedef struct packed {
        law_e                 law;
        logic [SCD_DIV_W-1:0] div;
        logic                 cpol;
        logic                 cpha;
    } cfg_t;

    localparam cfg_t CFG_RESET = '{law: LAW_EXP, div: '0, cpol: 1'b0, cpha: 1'b0};

    // Half period minus one, in bus cycles, for a latched configuration.
    function automatic logic [SCD_CNT_W-1:0] half_minus_one(cfg_t c);
        logic [SCD_EXP_W-1:0] e;
        logic [SCD_CNT_W:0]   wide;
        if (c.law == LAW_EXP) begin
            if (c.div > SCD_DIV_W'(SCD_EXP_MAX))
                e = SCD_EXP_W'(SCD_EXP_MAX);
            else
                e = c.div[SCD_EXP_W-1:0];
            wide = ((SCD_CNT_W+1)'(1) << e) - (SCD_CNT_W+1)'(1);
        end else begin
            wide = (SCD_CNT_W+1)'(c.div);
        end
        return wide[SCD_CNT_W-1:0];
    endfunction

endpackage

// File: rtl/spi_clkdiv_cfg.sv
module spi_clkdiv_cfg
    import spi_clkdiv_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 en_i,
    input  logic                 law_i,
    input  logic [SCD_DIV_W-1:0] div_i,
    input  logic                 cpol_i,
    input  logic                 cpha_i,
    output cfg_t                 cfg_q,
    output logic                 en_q,
    output logic [SCD_CNT_W-1:0] half_m1_o
);

    cfg_t cfg_d;

    always_comb begin
        cfg_d      = cfg_q;
        if (!en_i) begin
            cfg_d.law  = law_e'(law_i);
            cfg_d.div  = div_i;
            cfg_d.cpol = cpol_i;
            cfg_d.cpha = cpha_i;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= CFG_RESET;
            en_q  <= 1'b0;
        end else begin
            cfg_q <= cfg_d;
            en_q  <= en_i;
        end
    end

    assign half_m1_o = half_minus_one(cfg_q);

endmodule

// File: rtl/spi_clkdiv_cnt.sv
module spi_clkdiv_cnt
    import spi_clkdiv_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 active_i,
    input  logic [SCD_CNT_W-1:0] half_m1_i,
    output logic                 tick_o,
    output logic [SCD_CNT_W-1:0] cnt_q
);

    assign tick_o = active_i && (cnt_q == half_m1_i);

    always_ff @(posedge clk) begin
        if (rst || !active_i) begin
            cnt_q <= '0;
        end else if (tick_o) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + SCD_CNT_W'(1);
        end
    end

endmodule

// File: rtl/spi_clkdiv_edge.sv
module spi_clkdiv_edge (
    input  logic clk,
    input  logic rst,
    input  logic active_i,
    input  logic tick_i,
    input  logic cpol_i,
    input  logic cpha_i,
    output logic sclk_o,
    output logic launch_o,
    output logic sample_o
);

    logic lead_q;   // next toggle is a leading edge
    logic launch_side;

    assign launch_side = lead_q ^ cpha_i;
    assign launch_o    = tick_i &  launch_side;
    assign sample_o    = tick_i & ~launch_side;

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_o <= 1'b0;
            lead_q <= 1'b1;
        end else if (!active_i) begin
            sclk_o <= cpol_i;
            lead_q <= 1'b1;
        end else if (tick_i) begin
            sclk_o <= ~sclk_o;
            lead_q <= ~lead_q;
        end
    end

endmodule

// File: rtl/spi_clkdiv.sv
module spi_clkdiv
    import spi_clkdiv_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 en_i,
    input  logic                 law_i,
    input  logic [SCD_DIV_W-1:0] div_i,
    input  logic                 cpol_i,
    input  logic                 cpha_i,
    input  logic                 frame_i,
    output logic                 tick_o,
    output logic                 sclk_o,
    output logic                 launch_o,
    output logic                 sample_o
);

    cfg_t                 cfg_q;
    logic                 en_q;
    logic                 active;
    logic [SCD_CNT_W-1:0] half_m1;
    logic [SCD_CNT_W-1:0] cnt_q;

    spi_clkdiv_cfg u_cfg (
        .clk       (clk),
        .rst       (rst),
        .en_i      (en_i),
        .law_i     (law_i),
        .div_i     (div_i),
        .cpol_i    (cpol_i),
        .cpha_i    (cpha_i),
        .cfg_q     (cfg_q),
        .en_q      (en_q),
        .half_m1_o (half_m1)
    );

    assign active = en_q && frame_i;

    spi_clkdiv_cnt u_cnt (
        .clk       (clk),
        .rst       (rst),
        .active_i  (active),
        .half_m1_i (half_m1),
        .tick_o    (tick_o),
        .cnt_q     (cnt_q)
    );

    spi_clkdiv_edge u_edge (
        .clk      (clk),
        .rst      (rst),
        .active_i (active),
        .tick_i   (tick_o),
        .cpol_i   (cfg_q.cpol),
        .cpha_i   (cfg_q.cpha),
        .sclk_o   (sclk_o),
        .launch_o (launch_o),
        .sample_o (sample_o)
    );

endmodule

// File: rtl/spi_clkdiv_chk.sv
module spi_clkdiv_chk
    import spi_clkdiv_pkg::*;
(
    input logic                 clk,
    input logic                 rst,
    input logic                 en_i,
    input logic                 tick_o,
    input logic                 sclk_o,
    input logic                 launch_o,
    input logic                 sample_o,
    input logic                 active,
    input cfg_t                 cfg_q,
    input logic [SCD_CNT_W-1:0] half_m1,
    input logic [SCD_CNT_W-1:0] cnt_q
);

    AST_IDLE_LEVEL: assert property (@(posedge clk) disable iff (rst)
        !active |=> (sclk_o == $past(cfg_q.cpol))); // R7

    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(launch_o && sample_o)); // R10

    AST_STROBE_ON_TICK: assert property (@(posedge clk) disable iff (rst)
        (launch_o || sample_o) |-> tick_o); // R10

    AST_TOGGLE_ON_TICK: assert property (@(posedge clk) disable iff (rst)
        tick_o |=> (sclk_o != $past(sclk_o))); // R10

    AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (rst)
        (active && !tick_o) |=> $stable(sclk_o)); // R10

    AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (rst)
        en_i |=> $stable(cfg_q)); // R6

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
        active |-> (cnt_q <= half_m1)); // R4

    AST_EXP_CLAMP: assert property (@(posedge clk) disable iff (rst)
        (cfg_q.law == LAW_EXP) |-> (half_m1 <= SCD_CNT_W'((1 << SCD_EXP_MAX) - 1))); // R3

endmodule

bind spi_clkdiv spi_clkdiv_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .en_i     (en_i),
    .tick_o   (tick_o),
    .sclk_o   (sclk_o),
    .launch_o (launch_o),
    .sample_o (sample_o),
    .active   (active),
    .cfg_q    (cfg_q),
    .half_m1  (half_m1),
    .cnt_q    (cnt_q)
);

// File: tb/spi_clkdiv_tb.sv
module spi_clkdiv_tb;

    logic       clk = 1'b0;
    logic       rst;
    logic       en_i, law_i, cpol_i, cpha_i, frame_i;
    logic [7:0] div_i;
    logic       tick_o, sclk_o, launch_o, sample_o;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    spi_clkdiv u_dut (
        .clk(clk), .rst(rst), .en_i(en_i), .law_i(law_i), .div_i(div_i),
        .cpol_i(cpol_i), .cpha_i(cpha_i), .frame_i(frame_i),
        .tick_o(tick_o), .sclk_o(sclk_o), .launch_o(launch_o), .sample_o(sample_o)
    );

    // {law, N, expected half period}
    localparam int NV = 8;
    localparam int VEC [NV][3] = '{
        '{0,   0,   1},   // R5 exp
        '{0,   1,   2},   // R2
        '{0,   3,   8},   // R2
        '{0,   7, 128},   // R2
        '{1,   0,   1},   // R5 lin
        '{1,   1,   2},   // R4
        '{1,   9,  10},   // R4
        '{1, 255, 256}    // R4
    };

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Count falling edges until sclk_o differs from its present level.
    task automatic measure(output int n);
        logic prev;
        prev = sclk_o;
        n = 0;
        for (int k = 0; k < 70000; k++) begin
            @(negedge clk);
            n++;
            if (sclk_o != prev) break;
        end
    endtask

    task automatic wait_tick();
        for (int k = 0; k < 1000; k++) begin
            @(negedge clk);
            if (tick_o) break;
        end
    endtask

    task automatic configure(input logic law, input logic [7:0] n,
                             input logic pol, input logic pha);
        @(negedge clk);
        frame_i = 1'b0;
        en_i    = 1'b0;
        law_i   = law;
        div_i   = n;
        cpol_i  = pol;
        cpha_i  = pha;
        @(negedge clk);
        en_i = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        int m;
        rst = 1'b1; en_i = 1'b0; law_i = 1'b0; div_i = '0;
        cpol_i = 1'b0; cpha_i = 1'b0; frame_i = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1 sclk in reset", sclk_o, 0);
        chk("R1 strobes in reset", {tick_o, launch_o, sample_o}, 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 sclk after reset", sclk_o, 0);
        chk("R1 tick after reset", tick_o, 0);

        // Table walk: first toggle (R9) and steady half period
        for (int v = 0; v < NV; v++) begin
            configure(VEC[v][0][0], 8'(VEC[v][1]), 1'b0, 1'b0);
            frame_i = 1'b1;
            measure(m);
            chk($sformatf("R9 first edge law%0d N%0d", VEC[v][0], VEC[v][1]), m, VEC[v][2]);
            measure(m);
            chk($sformatf("R2/R4/R5 half law%0d N%0d", VEC[v][0], VEC[v][1]), m, VEC[v][2]);
        end

        // R3: exponent clamp
        configure(1'b0, 8'd20, 1'b0, 1'b0);
        frame_i = 1'b1;
        measure(m);
        chk("R3 clamp N=20", m, 32768);

        // R6: changes while enabled ignored
        configure(1'b1, 8'd3, 1'b0, 1'b0);
        div_i = 8'd9; cpol_i = 1'b1; law_i = 1'b0;
        frame_i = 1'b1;
        measure(m);
        chk("R6 divider frozen while enabled", m, 4);
        frame_i = 1'b0;
        repeat (3) @(negedge clk);
        chk("R6 polarity frozen while enabled", sclk_o, 0);
        en_i = 1'b0; law_i = 1'b1;
        @(negedge clk);
        en_i = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk("R6/R7 new polarity after disable", sclk_o, 1);
        frame_i = 1'b1;
        measure(m);
        chk("R6 new divider after disable", m, 10);

        // R9: partial count discarded
        frame_i = 1'b0;
        @(negedge clk);
        frame_i = 1'b1;
        repeat (4) @(negedge clk);
        frame_i = 1'b0;
        repeat (2) @(negedge clk);
        frame_i = 1'b1;
        measure(m);
        chk("R9 restart after partial count", m, 10);

        // R7: mid-period drop returns to idle level (cpol=1, sclk now 0)
        chk("R7 sclk low mid-frame", sclk_o, 0);
        frame_i = 1'b0;
        @(negedge clk);
        chk("R7 idle level after drop", sclk_o, 1);
        repeat (5) @(negedge clk);
        chk("R7 idle level held", sclk_o, 1);

        // R8: phase 0
        configure(1'b1, 8'd1, 1'b0, 1'b0);
        frame_i = 1'b1;
        wait_tick();
        chk("R8 pha0 leading launch", {launch_o, sample_o}, 2'b10);
        wait_tick();
        chk("R8 pha0 trailing sample", {launch_o, sample_o}, 2'b01);
        // R8: phase 1
        configure(1'b1, 8'd1, 1'b0, 1'b1);
        frame_i = 1'b1;
        wait_tick();
        chk("R8 pha1 leading sample", {launch_o, sample_o}, 2'b01);
        chk("R10 sclk before toggle", sclk_o, 0);
        @(negedge clk);
        chk("R10 sclk after tick", sclk_o, 1);
        wait_tick();
        chk("R8 pha1 trailing launch", {launch_o, sample_o}, 2'b10);
        frame_i = 1'b0;
        @(negedge clk);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #950000;
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule